// File: doc/BRIEF.md
# Guarded Serial EEPROM Slave

This block is the command and protection core of a small serial EEPROM. It holds a 512-byte array and answers SPI mode 0 transfers: the host pulls chip select low, shifts bits in on the serial clock rising edge, and the block returns bits on the falling edge. Six one-byte commands are decoded. Two of them set or clear a write-enable latch. Two of them read or program a small status register. The last two read or write the array, with the ninth address bit carried inside the command byte.

A write reaches the array only when it clears three separate guards. The first is the write-enable latch, which is cleared at power-up. The second is a two-bit zone field in the status register that locks the upper quarter, the upper half, or all of the array. The third is a hardware enable pin: when that pin is low, the array and the status register are both locked. An accepted write or status write takes effect when chip select rises on a byte boundary. A busy timer then runs. While the timer runs, only status reads are served. The latch clears when the timer expires.

The serial clock and chip select are oversampled by the system clock. The main state machine has eight states. ST_IDLE is entered whenever chip select is high. ST_OPCODE collects the command byte. From ST_OPCODE the machine goes to ST_ADDR for a read or a write, to ST_SDATA for a status write, to ST_STAT for a status read, and to ST_DROP for the latch commands, for unknown codes, and for any command other than a status read that arrives while busy. ST_ADDR goes to ST_RDATA for a read and to ST_WDATA for a write. Every state returns to ST_IDLE when chip select rises.

Top module: `eeprom_guard_slave`

## Requirements
- R1: After reset the status register reads 00h and every array byte reads 00h.
- R2: Command 06h sets the write-enable latch and command 04h clears it. Both act on the eighth bit of the command byte, and status bit 1 shows the latch.
- R3: When the latch is clear, a write (02h) and a status write (01h) change nothing and do not start the busy timer.
- R4: When hw_wr_en is low, array writes and status writes are refused. The latch commands still work.
- R5: The zone field (status bits 3:2) locks these addresses: 00 locks none, 01 locks 180h-1FFh, 10 locks 100h-1FFh, 11 locks all of 000h-1FFh. A write into a locked address is refused, and the latch stays set.
- R6: The status byte is {0000, zone[1:0], latch, busy}. A status write copies bits 3:2 of its data byte into the zone field and ignores the other bits.
- R7: Read (03h) and write (02h) take address bit 8 from bit 3 of the command byte, then a low address byte. A read streams bytes from successive addresses while chip select stays low, and it wraps from 1FFh to 000h.
- R8: A write or status write is committed only when chip select rises after one or more complete data bytes and with no partial byte pending. The last complete data byte is the one used. An aborted frame leaves the array, the status register and the latch unchanged.
- R9: A committed write sets busy (status bit 0) for BUSY_CYCLES clock cycles. When busy ends, the latch clears.
- R10: While busy is set, every command except the status read (05h) is ignored.
- R11: A status read returns the live status byte again after each byte for as long as chip select stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial lines |
| rst_n | input | 1 | Active-low reset |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_sck | input | 1 | Serial clock, mode 0 |
| spi_mosi | input | 1 | Serial data into the block |
| spi_miso | output | 1 | Serial data out of the block; low while deselected |
| hw_wr_en | input | 1 | Hardware write enable; low makes the device read-only |

## Verification
Writes are tried in several ways, and each way isolates one guard. A write with the latch clear tests the latch alone. A write with the pin low and the latch set tests the pin alone. Writes on each side of the zone boundaries 180h and 100h, and at 000h under full lock, test the zone alone. A frame cut off mid-byte checks that the commit waits for a byte boundary, and the status reads after these frames show that refused writes leave the latch set. Commands sent during busy, a sequential read across 1FFh, and a status write with extra bits set separate the busy gating, the address wrap and the status field mask.

// File: rtl/egs_pkg.sv
package egs_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_OPCODE,
        ST_ADDR,
        ST_WDATA,
        ST_SDATA,
        ST_RDATA,
        ST_STAT,
        ST_DROP
    } egs_state_t;

    localparam logic [7:0] OP_LATCH_SET = 8'h06;
    localparam logic [7:0] OP_LATCH_CLR = 8'h04;
    localparam logic [7:0] OP_STAT_RD   = 8'h05;
    localparam logic [7:0] OP_STAT_WR   = 8'h01;
    localparam logic [7:0] OP_ARR_RD    = 8'h03;
    localparam logic [7:0] OP_ARR_WR    = 8'h02;
    localparam logic [7:0] OP_HI_MASK   = 8'hF7;
endpackage

// File: rtl/egs_edge.sv
module egs_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic sck,
    input  logic cs_n,
    output logic sck_rise,
    output logic sck_fall,
    output logic cs_rise
);
    logic sck_q;
    logic cs_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sck_q <= 1'b0;
            cs_q  <= 1'b1;
        end else begin
            sck_q <= sck;
            cs_q  <= cs_n;
        end
    end

    assign sck_rise = sck & ~sck_q & ~cs_n;
    assign sck_fall = ~sck & sck_q & ~cs_n;
    assign cs_rise  = cs_n & ~cs_q;
endmodule

// File: rtl/egs_zone.sv
module egs_zone #(
    parameter int ADDR_W = 9
) (
    input  logic [1:0]        zone,
    input  logic [ADDR_W-1:0] addr,
    output logic              locked
);
    localparam int DEPTH   = 1 << ADDR_W;
    localparam int QUARTER = (DEPTH * 3) / 4;
    localparam int HALF    = DEPTH / 2;

    always_comb begin
        unique case (zone)
            2'b00:   locked = 1'b0;
            2'b01:   locked = (int'(addr) >= QUARTER);
            2'b10:   locked = (int'(addr) >= HALF);
            default: locked = 1'b1;
        endcase
    end
endmodule

// File: rtl/egs_timer.sv
module egs_timer #(
    parameter int BUSY_CYCLES = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy,
    output logic done
);
    localparam int CNT_W = $clog2(BUSY_CYCLES + 1);
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              cnt <= '0;
        else if (start)          cnt <= CNT_W'(BUSY_CYCLES);
        else if (cnt != '0)      cnt <= cnt - 1'b1;
    end

    assign busy = (cnt != '0);
    assign done = (cnt == CNT_W'(1));
endmodule

// File: rtl/eeprom_guard_slave.sv
module eeprom_guard_slave
    import egs_pkg::*;
#(
    parameter int ADDR_W      = 9,
    parameter int BUSY_CYCLES = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic spi_cs_n,
    input  logic spi_sck,
    input  logic spi_mosi,
    output logic spi_miso,
    input  logic hw_wr_en
);
    localparam int DEPTH = 1 << ADDR_W;

    egs_state_t        state, state_nx;
    logic              sck_rise, sck_fall, cs_rise;
    logic [2:0]        bitcnt;
    logic [6:0]        sh;
    logic [7:0]        byte_in, tx, wdata;
    logic              byte_done, have_byte, is_read, a_hi;
    logic [ADDR_W-1:0] addr, addr_in;
    logic              wel, busy, busy_done, zone_locked;
    logic [1:0]        bp;
    logic [7:0]        status;
    logic              frame_ok, commit_arr, commit_sr, mem_we;
    logic [7:0]        mem [DEPTH];

    egs_edge u_edge (
        .clk(clk), .rst_n(rst_n), .sck(spi_sck), .cs_n(spi_cs_n),
        .sck_rise(sck_rise), .sck_fall(sck_fall), .cs_rise(cs_rise)
    );

    egs_zone #(.ADDR_W(ADDR_W)) u_zone (
        .zone(bp), .addr(addr), .locked(zone_locked)
    );

    egs_timer #(.BUSY_CYCLES(BUSY_CYCLES)) u_timer (
        .clk(clk), .rst_n(rst_n), .start(commit_arr | commit_sr),
        .busy(busy), .done(busy_done)
    );

    assign byte_in    = {sh, spi_mosi};
    assign byte_done  = sck_rise && (bitcnt == 3'd7);
    assign addr_in    = ADDR_W'({a_hi, byte_in});
    assign status     = {4'b0000, bp, wel, busy};
    assign frame_ok   = cs_rise && (bitcnt == 3'd0) && have_byte && wel && hw_wr_en && !busy;
    assign commit_arr = frame_ok && (state == ST_WDATA) && !zone_locked;
    assign commit_sr  = frame_ok && (state == ST_SDATA);
    assign mem_we     = commit_arr;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // next state
    always_comb begin
        state_nx = state;
        if (spi_cs_n) begin
            state_nx = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE, ST_OPCODE: begin
                    state_nx = ST_OPCODE;
                    if (byte_done) begin
                        if (busy)
                            state_nx = (byte_in == OP_STAT_RD) ? ST_STAT : ST_DROP;
                        else if (byte_in == OP_STAT_RD)
                            state_nx = ST_STAT;
                        else if (byte_in == OP_STAT_WR)
                            state_nx = ST_SDATA;
                        else if ((byte_in & OP_HI_MASK) == OP_ARR_RD ||
                                 (byte_in & OP_HI_MASK) == OP_ARR_WR)
                            state_nx = ST_ADDR;
                        else
                            state_nx = ST_DROP;
                    end
                end
                ST_ADDR:  if (byte_done) state_nx = is_read ? ST_RDATA : ST_WDATA;
                ST_WDATA, ST_SDATA, ST_RDATA, ST_STAT, ST_DROP: state_nx = state;
                default:  state_nx = ST_IDLE;
            endcase
        end
    end

    // datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bitcnt    <= '0;
            sh        <= '0;
            tx        <= '0;
            wdata     <= '0;
            have_byte <= 1'b0;
            is_read   <= 1'b0;
            a_hi      <= 1'b0;
            addr      <= '0;
            wel       <= 1'b0;
            bp        <= 2'b00;
            spi_miso  <= 1'b0;
        end else begin
            if (spi_cs_n) begin
                bitcnt    <= '0;
                have_byte <= 1'b0;
                spi_miso  <= 1'b0;
            end
            if (sck_rise) begin
                bitcnt <= bitcnt + 3'd1;
                sh     <= byte_in[6:0];
            end
            if (sck_fall) begin
                spi_miso <= tx[7];
                tx       <= {tx[6:0], 1'b0};
            end
            if (byte_done) begin
                unique case (state)
                    ST_IDLE, ST_OPCODE: begin
                        tx      <= status;
                        a_hi    <= byte_in[3];
                        is_read <= ((byte_in & OP_HI_MASK) == OP_ARR_RD);
                        if (!busy && byte_in == OP_LATCH_SET) wel <= 1'b1;
                        if (!busy && byte_in == OP_LATCH_CLR) wel <= 1'b0;
                    end
                    ST_ADDR: begin
                        if (is_read) begin
                            tx   <= mem[addr_in];
                            addr <= addr_in + 1'b1;
                        end else begin
                            addr <= addr_in;
                        end
                    end
                    ST_RDATA: begin
                        tx   <= mem[addr];
                        addr <= addr + 1'b1;
                    end
                    ST_STAT: tx <= status;
                    ST_WDATA, ST_SDATA: begin
                        wdata     <= byte_in;
                        have_byte <= 1'b1;
                    end
                    default: ;
                endcase
            end
            if (commit_sr) bp <= wdata[3:2];
            if (busy_done) wel <= 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (mem_we) begin
            mem[addr] <= wdata;
        end
    end
endmodule

// File: rtl/egs_checker.sv
module egs_checker #(
    parameter int ADDR_W      = 9,
    parameter int BUSY_CYCLES = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mem_we,
    input logic              wel,
    input logic              hw_wr_en,
    input logic [1:0]        bp,
    input logic [ADDR_W-1:0] addr,
    input logic              busy
);
    localparam int DEPTH = 1 << ADDR_W;
    localparam int CW    = $clog2(BUSY_CYCLES + 2);
    logic [CW-1:0] run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    run <= '0;
        else if (busy) run <= run + 1'b1;
        else           run <= '0;
    end

    p_wr_needs_latch_r3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> wel);

    p_wr_needs_pin_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> hw_wr_en);

    p_zone_respected_r5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (bp == 2'b00) ||
                   (bp == 2'b01 && int'(addr) < (DEPTH * 3) / 4) ||
                   (bp == 2'b10 && int'(addr) < DEPTH / 2));

    p_busy_blocks_r10: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !mem_we);

    p_latch_cleared_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> !wel);

    p_busy_length_r9: assert property (@(posedge clk) disable iff (!rst_n)
        int'(run) <= BUSY_CYCLES);
endmodule

bind eeprom_guard_slave egs_checker #(.ADDR_W(ADDR_W), .BUSY_CYCLES(BUSY_CYCLES)) u_chk (
    .clk(clk), .rst_n(rst_n), .mem_we(mem_we), .wel(wel), .hw_wr_en(hw_wr_en),
    .bp(bp), .addr(addr), .busy(busy)
);

// File: tb/eeprom_guard_slave_test.sv
`timescale 1ns/1ps
module eeprom_guard_slave_test;
    localparam int BUSY = 600;

    logic clk = 1'b0;
    logic rst_n, cs_n, sck, mosi, miso, hw;
    int   vectors = 0;
    int   fails   = 0;
    bit   finished = 1'b0;
    logic [7:0] exp_q [$];
    string      tag_q [$];
    logic [7:0] rx_byte;
    event       rx_ev;

    always #2 clk = ~clk;

    eeprom_guard_slave #(.ADDR_W(9), .BUSY_CYCLES(BUSY)) uut (
        .clk(clk), .rst_n(rst_n), .spi_cs_n(cs_n), .spi_sck(sck),
        .spi_mosi(mosi), .spi_miso(miso), .hw_wr_en(hw)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic shift_bits(input logic [7:0] b, input int n, output logic [7:0] r);
        r = '0;
        for (int i = 7; i > 7 - n; i--) begin
            mosi = b[i];
            tick(2);
            r[i] = miso;
            sck = 1'b1;
            tick(4);
            sck = 1'b0;
            tick(2);
        end
    endtask

    task automatic sel();
        cs_n = 1'b0;
        tick(4);
    endtask

    task automatic desel();
        tick(4);
        cs_n = 1'b1;
        tick(6);
    endtask

    task automatic put(input logic [7:0] b);
        logic [7:0] r;
        shift_bits(b, 8, r);
    endtask

    task automatic get(input logic [7:0] e, input string tag);
        logic [7:0] r;
        exp_q.push_back(e);
        tag_q.push_back(tag);
        shift_bits(8'h00, 8, r);
        rx_byte = r;
        -> rx_ev;
        tick(1);
    endtask

    task automatic cmd(input logic [7:0] op);
        sel(); put(op); desel();
    endtask

    task automatic stat_chk(input logic [7:0] e, input string tag);
        sel(); put(8'h05); get(e, tag); desel();
    endtask

    task automatic wr(input logic [8:0] a, input logic [7:0] d);
        sel(); put({4'h0, a[8], 3'b010}); put(a[7:0]); put(d); desel();
    endtask

    task automatic wrsr(input logic [7:0] d);
        sel(); put(8'h01); put(d); desel();
    endtask

    task automatic settle();
        tick(BUSY + 100);
    endtask

    task automatic rd_start(input logic [8:0] a);
        sel(); put({4'h0, a[8], 3'b011}); put(a[7:0]);
    endtask

    // monitor: pops expectations as bytes arrive
    initial begin
        forever begin
            @(rx_ev);
            vectors++;
            if (exp_q.size() == 0) begin
                fails++;
                $display("FAIL unexpected byte: actual %02h expected none", rx_byte);
            end else begin
                logic [7:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (rx_byte !== e) begin
                    fails++;
                    $display("FAIL %s: actual %02h expected %02h", t, rx_byte, e);
                end
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] r;
        rst_n = 1'b0; cs_n = 1'b1; sck = 1'b0; mosi = 1'b0; hw = 1'b1;
        tick(5);
        rst_n = 1'b1;
        tick(5);

        // R1 reset state, R11 repeated status
        sel(); put(8'h05); get(8'h00, "R1 status"); get(8'h00, "R11 repeat"); desel();
        rd_start(9'h010); get(8'h00, "R1 array"); desel();

        // R3 write without latch
        wr(9'h010, 8'hA5); tick(20);
        stat_chk(8'h00, "R3 no busy");
        rd_start(9'h010); get(8'h00, "R3 array"); desel();

        // R2 latch set / clear
        cmd(8'h06); stat_chk(8'h02, "R2 set");
        cmd(8'h04); stat_chk(8'h00, "R2 clear");

        // R9 committed write, R10 busy gating, R11 live status
        cmd(8'h06); wr(9'h010, 8'hA5);
        stat_chk(8'h03, "R9 busy");
        cmd(8'h04);
        wr(9'h011, 8'h5A);
        stat_chk(8'h03, "R10 ignored");
        settle();
        stat_chk(8'h00, "R9 latch dropped");
        rd_start(9'h010); get(8'hA5, "R7 read"); get(8'h00, "R10 second write"); desel();

        // R8 partial byte abort
        cmd(8'h06);
        sel(); put(8'h02); put(8'h20); put(8'hCC); shift_bits(8'hF0, 4, r); desel();
        tick(20);
        stat_chk(8'h02, "R8 latch kept");
        rd_start(9'h020); get(8'h00, "R8 array"); desel();
        // R8 no data byte
        sel(); put(8'h02); put(8'h21); desel(); tick(20);
        stat_chk(8'h02, "R8 empty frame");
        cmd(8'h04);

        // R4 hardware pin low
        hw = 1'b0;
        cmd(8'h06); stat_chk(8'h02, "R4 latch works");
        wr(9'h030, 8'h11); tick(20);
        wrsr(8'h0C); tick(20);
        stat_chk(8'h02, "R4 status locked");
        rd_start(9'h030); get(8'h00, "R4 array locked"); desel();
        hw = 1'b1;
        cmd(8'h04);

        // R6 status write, zone 01; R5 boundaries
        cmd(8'h06); wrsr(8'h04); settle();
        stat_chk(8'h04, "R6 zone 01");
        cmd(8'h06); wr(9'h180, 8'h22); tick(20);
        stat_chk(8'h06, "R5 locked 180");
        wr(9'h17F, 8'h33); settle();
        rd_start(9'h17F); get(8'h33, "R5 17F"); get(8'h00, "R5 180"); desel();

        // zone 10
        cmd(8'h06); wrsr(8'h08); settle();
        cmd(8'h06); wr(9'h100, 8'h55); tick(20);
        wr(9'h0FF, 8'h44); settle();
        rd_start(9'h0FF); get(8'h44, "R5 0FF"); get(8'h00, "R5 100"); desel();

        // zone 11
        cmd(8'h06); wrsr(8'h0C); settle();
        cmd(8'h06); wr(9'h000, 8'h66); tick(20);
        stat_chk(8'h0E, "R5 all locked");
        wrsr(8'h00); settle();
        stat_chk(8'h00, "R6 zone cleared");

        // R7 wrap
        cmd(8'h06); wr(9'h000, 8'h88); settle();
        cmd(8'h06); wr(9'h1FF, 8'h77); settle();
        rd_start(9'h1FF); get(8'h77, "R7 1FF"); get(8'h88, "R7 wrap 000"); get(8'h00, "R7 001"); desel();

        // R6 mask of extra bits
        cmd(8'h06); wrsr(8'hF3); settle();
        stat_chk(8'h00, "R6 mask zero");
        cmd(8'h06); wrsr(8'hFF); settle();
        stat_chk(8'h0C, "R6 mask ones");

        tick(10);
        if (exp_q.size() != 0) begin
            fails++;
            $display("FAIL scoreboard: actual %0d left expected 0", exp_q.size());
        end
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule